// File: doc/BRIEF.md
# Serial Dot-Matrix Command Receiver

This block takes 8-bit command words from a three-wire serial link made up of a data line, a shift clock and an active-low frame strobe. It turns each completed word into an update of a 200-bit dot store or of the display control state. The dot store holds 8 characters of 5 rows by 5 columns. The link pins are asynchronous to the system clock. They are synchronised, and their edges are detected in the system clock domain. While the frame strobe is low, each rising edge of the shift clock captures one data bit, least significant bit first. The rising edge of the frame strobe hands the accumulated byte to the decoder.

The top three bits of a byte select what the byte does. Values 0 to 4 write the low five bits as one row of the character currently pointed to. Value 5 moves that pointer. Value 6 with zero low bits wipes the dot store. Value 7 carries a control word: a brightness level, lamp test or power down. A display scanner reads the dot store through a combinational read port and takes the brightness, lamp-test and power-down state from dedicated outputs.

Top module: `dot_cmd_rx`

## Requirements
- R1: After rst_ni is released, char_addr_o is 0, bright_o is 0 (full brightness), lamp_test_o is 0, power_down_o is 0, and every dot-store row reads 0.
- R2: Shift-clock rising edges that occur while frame_ni is high do not change the captured byte.
- R3: Bits are captured least significant first on shift-clock rising edges while frame_ni is low, and the byte is decoded on the rising edge of frame_ni.
- R4: A byte with bits 7:5 equal to N (0 to 4) writes row N of the addressed character. Byte bit 4 is stored as column 0 and byte bit 0 as column 4. Bit c of rd_cols_o is column c.
- R5: A byte with bits 7:5 = 101 sets char_addr_o to bits 2:0. Bits 4:3 have no effect.
- R6: Byte 0xC0 zeroes every row of every character. Bytes 0xC1 to 0xDF change nothing.
- R7: Bytes 0xF0 to 0xF6 set bright_o to bits 2:0 and clear both lamp_test_o and power_down_o.
- R8: Byte 0xF8 sets lamp_test_o and byte 0xFF sets power_down_o. Neither byte changes bright_o or the other flag.
- R9: Bytes 0xF7 and 0xF9 to 0xFE change no output.
- R10: Row writes are stored while power_down_o is 1, and they leave it at 1.
- R11: A frame with fewer than eight clocks decodes the shift register as it stands. That is the k new bits above bits 7:k of the previous contents.
- R12: Asserting rst_ni mid-frame clears the dot store and the control state at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdat_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock |
| frame_ni | input | 1 | Frame strobe; low enables shifting, rising edge decodes |
| rd_char_i | input | 3 | Scanner read character index |
| rd_row_i | input | 3 | Scanner read row index |
| rd_cols_o | output | 5 | Dot row at the read address; bit c is column c |
| char_addr_o | output | 3 | Current character pointer |
| bright_o | output | 3 | Brightness level, 0 = full |
| lamp_test_o | output | 1 | Lamp test active |
| power_down_o | output | 1 | Power down active |

## Verification
The bench builds the block with its defaults: 8 characters, 5 rows, 7 brightness levels and two synchroniser stages. With these values every character pointer value, every row opcode and the full control-word space can be reached. Together with the read port, this lets the bench observe the store contents and check that ignored codes leave both the store and the control outputs unchanged. Partial frames, and clocks given outside a frame, are checked through the byte that the decoder then acts on.

// File: rtl/dot_cmd_pkg.sv
package dot_cmd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned FIELD_W = BYTE_W - OP_W;
  localparam int unsigned BR_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ROW0  = 3'd0,
    OP_ROW1  = 3'd1,
    OP_ROW2  = 3'd2,
    OP_ROW3  = 3'd3,
    OP_ROW4  = 3'd4,
    OP_CHAR  = 3'd5,
    OP_CLEAR = 3'd6,
    OP_CTRL  = 3'd7
  } op_e;

  // control-word low fields
  localparam logic [FIELD_W-1:0] CW_LAMP = 5'b11000;
  localparam logic [FIELD_W-1:0] CW_PDN  = 5'b11111;
endpackage

// File: rtl/dot_sync.sv
module dot_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dot_shift.sv
module dot_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sr_q;

  // LSB first: new bit enters at the top, first bit ends at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[W-1:1]};
  end

  assign data_o = sr_q;
endmodule

// File: rtl/dot_decode.sv
module dot_decode
  import dot_cmd_pkg::*;
#(
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned N_ROWS  = 5,
  parameter int unsigned LEVELS  = 7,
  localparam int unsigned CHAR_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1,
  localparam int unsigned ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               we_o,
  output logic [ROW_W-1:0]   wrow_o,
  output logic [FIELD_W-1:0] wdata_o,
  output logic               clr_o,
  output logic [CHAR_W-1:0]  char_o,
  output logic [BR_W-1:0]    bright_o,
  output logic               lamp_o,
  output logic               pdn_o
);
  logic [OP_W-1:0]    op;
  logic [FIELD_W-1:0] fld;
  logic               is_char, is_bri, is_lamp, is_pdn;

  assign op  = byte_i[BYTE_W-1:FIELD_W];
  assign fld = byte_i[FIELD_W-1:0];

  assign we_o    = vld_i && (op < OP_W'(N_ROWS));
  assign wrow_o  = ROW_W'(op);
  assign clr_o   = vld_i && (op == OP_CLEAR) && (fld == '0);
  assign is_char = vld_i && (op == OP_CHAR);
  assign is_bri  = vld_i && (op == OP_CTRL) && (fld[4:3] == 2'b10)
                   && ({1'b0, fld[2:0]} < 4'(LEVELS));
  assign is_lamp = vld_i && (op == OP_CTRL) && (fld == CW_LAMP);
  assign is_pdn  = vld_i && (op == OP_CTRL) && (fld == CW_PDN);

  // byte bit 4 is column 0
  for (genvar c = 0; c < FIELD_W; c++) begin : g_rev
    assign wdata_o[c] = fld[FIELD_W-1-c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o   <= '0;
      bright_o <= '0;
      lamp_o   <= 1'b0;
      pdn_o    <= 1'b0;
    end else begin
      if (is_char) char_o <= byte_i[CHAR_W-1:0];
      if (is_bri) begin
        bright_o <= fld[BR_W-1:0];
        lamp_o   <= 1'b0;
        pdn_o    <= 1'b0;
      end
      if (is_lamp) lamp_o <= 1'b1;
      if (is_pdn)  pdn_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/dot_ram.sv
module dot_ram #(
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned N_ROWS  = 5,
  parameter int unsigned N_COLS  = 5,
  localparam int unsigned CHAR_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1,
  localparam int unsigned ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int unsigned DEPTH  = N_CHARS * N_ROWS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CHAR_W-1:0] wchar_i,
  input  logic [ROW_W-1:0]  wrow_i,
  input  logic [N_COLS-1:0] wdata_i,
  input  logic              clr_i,
  input  logic [CHAR_W-1:0] rchar_i,
  input  logic [ROW_W-1:0]  rrow_i,
  output logic [N_COLS-1:0] rdata_o
);
  logic [N_COLS-1:0] mem_q [DEPTH];
  int unsigned widx, ridx;

  always_comb begin
    widx = int'(wchar_i) * N_ROWS + int'(wrow_i);
    ridx = int'(rchar_i) * N_ROWS + int'(rrow_i);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mem_q[e] <= '0;
      else if (clr_i)               mem_q[e] <= '0;
      else if (we_i && widx == e)   mem_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(rchar_i) < N_CHARS && int'(rrow_i) < N_ROWS) rdata_o = mem_q[ridx];
  end
endmodule

// File: rtl/dot_cmd_rx.sv
module dot_cmd_rx
  import dot_cmd_pkg::*;
#(
  parameter int unsigned N_CHARS     = 8,
  parameter int unsigned N_ROWS      = 5,
  parameter int unsigned LEVELS      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CHAR_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1,
  localparam int unsigned ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdat_i,
  input  logic               sclk_i,
  input  logic               frame_ni,
  input  logic [CHAR_W-1:0]  rd_char_i,
  input  logic [ROW_W-1:0]   rd_row_i,
  output logic [FIELD_W-1:0] rd_cols_o,
  output logic [CHAR_W-1:0]  char_addr_o,
  output logic [BR_W-1:0]    bright_o,
  output logic               lamp_test_o,
  output logic               power_down_o
);
  logic [2:0]         pins_s;
  logic               sclk_prev_q, frame_prev_q;
  logic               shift_en, cmd_vld;
  logic [BYTE_W-1:0]  cmd_byte;
  logic               we, clr;
  logic [ROW_W-1:0]   wrow;
  logic [FIELD_W-1:0] wdata;

  // {frame, sclk, data}; frame idles high
  dot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({frame_ni, sclk_i, sdat_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q  <= 1'b0;
      frame_prev_q <= 1'b1;
    end else begin
      sclk_prev_q  <= pins_s[1];
      frame_prev_q <= pins_s[2];
    end
  end

  assign shift_en = pins_s[1] && !sclk_prev_q && !pins_s[2];
  assign cmd_vld  = pins_s[2] && !frame_prev_q;

  dot_shift #(.W(BYTE_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (pins_s[0]),
    .data_o (cmd_byte)
  );

  dot_decode #(.N_CHARS(N_CHARS), .N_ROWS(N_ROWS), .LEVELS(LEVELS)) i_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (cmd_vld),
    .byte_i  (cmd_byte),
    .we_o    (we),
    .wrow_o  (wrow),
    .wdata_o (wdata),
    .clr_o   (clr),
    .char_o  (char_addr_o),
    .bright_o(bright_o),
    .lamp_o  (lamp_test_o),
    .pdn_o   (power_down_o)
  );

  dot_ram #(.N_CHARS(N_CHARS), .N_ROWS(N_ROWS), .N_COLS(FIELD_W)) i_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wchar_i(char_addr_o),
    .wrow_i (wrow),
    .wdata_i(wdata),
    .clr_i  (clr),
    .rchar_i(rd_char_i),
    .rrow_i (rd_row_i),
    .rdata_o(rd_cols_o)
  );
endmodule

// File: rtl/dot_cmd_rx_chk.sv
module dot_cmd_rx_chk #(
  parameter int unsigned CHAR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_vld_i,
  input logic [7:0]        cmd_byte_i,
  input logic [CHAR_W-1:0] char_addr_i,
  input logic [2:0]        bright_i,
  input logic              lamp_i,
  input logic              pdn_i
);
  logic is_bri;
  assign is_bri = cmd_vld_i && cmd_byte_i[7:3] == 5'b11110 && cmd_byte_i[2:0] != 3'b111;

  p_bright_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bri |=> (bright_i == $past(cmd_byte_i[2:0])) && !lamp_i && !pdn_i);

  p_lamp_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_byte_i == 8'hF8) |=> lamp_i && $stable(bright_i) && $stable(pdn_i));

  p_pdn_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_byte_i == 8'hFF) |=> pdn_i && $stable(bright_i) && $stable(lamp_i));

  p_char_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_byte_i[7:5] == 3'b101) |=> char_addr_i == $past(cmd_byte_i[CHAR_W-1:0]));

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_i |=> $stable(bright_i) && $stable(lamp_i) && $stable(pdn_i) && $stable(char_addr_i));

  p_single_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> !cmd_vld_i);
endmodule

bind dot_cmd_rx dot_cmd_rx_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_vld_i  (cmd_vld),
  .cmd_byte_i (cmd_byte),
  .char_addr_i(char_addr_o),
  .bright_i   (bright_o),
  .lamp_i     (lamp_test_o),
  .pdn_i      (power_down_o)
);

// File: tb/test_dot_cmd_rx.sv
module test_dot_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {byte, bright, lamp, pdn, char} after the byte
  localparam logic [15:0] VEC [NV] = '{
    {8'hF3, 3'd3, 1'b0, 1'b0, 3'd0},  // R7
    {8'hF8, 3'd3, 1'b1, 1'b0, 3'd0},  // R8
    {8'hF7, 3'd3, 1'b1, 1'b0, 3'd0},  // R9
    {8'hFB, 3'd3, 1'b1, 1'b0, 3'd0},  // R9
    {8'hF5, 3'd5, 1'b0, 1'b0, 3'd0},  // R7
    {8'hFF, 3'd5, 1'b0, 1'b1, 3'd0},  // R8
    {8'hA6, 3'd5, 1'b0, 1'b1, 3'd6},  // R5
    {8'hBA, 3'd5, 1'b0, 1'b1, 3'd2},  // R5
    {8'hF0, 3'd0, 1'b0, 1'b0, 3'd2},  // R7
    {8'hC3, 3'd0, 1'b0, 1'b0, 3'd2},  // R6
    {8'hFF, 3'd0, 1'b0, 1'b1, 3'd2},  // R8
    {8'hF8, 3'd0, 1'b1, 1'b1, 3'd2},  // R8
    {8'hF6, 3'd6, 1'b0, 1'b0, 3'd2}   // R7
  };

  logic clk = 1'b0, rst_ni = 1'b0, sdat = 1'b0, sclk = 1'b0, frame_n = 1'b1;
  logic [2:0] rd_char = '0, rd_row = '0;
  logic [4:0] rd_cols;
  logic [2:0] char_addr, bright;
  logic lamp, pdn;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dot_cmd_rx i_dot_cmd_rx (
    .clk_i(clk), .rst_ni(rst_ni), .sdat_i(sdat), .sclk_i(sclk), .frame_ni(frame_n),
    .rd_char_i(rd_char), .rd_row_i(rd_row), .rd_cols_o(rd_cols),
    .char_addr_o(char_addr), .bright_o(bright), .lamp_test_o(lamp), .power_down_o(pdn)
  );

  function automatic logic [4:0] rev5(input logic [4:0] v);
    for (int i = 0; i < 5; i++) rev5[i] = v[4-i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdat = b; wclk(3); sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(3);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    frame_n = 1'b0; wclk(4);
    for (int i = 0; i < n; i++) pulse_bit(v[i]);
    wclk(3); frame_n = 1'b1; wclk(8);
  endtask

  task automatic send_byte(input logic [7:0] v);
    send_bits(v, 8);
  endtask

  task automatic rd(input int c, input int r, output int v);
    rd_char = 3'(c); rd_row = 3'(r); #1; v = int'(rd_cols);
  endtask

  task automatic chk_ctrl(input string req, input int b, input int l, input int p, input int c);
    chk({req, " bright"}, int'(bright), b);
    chk({req, " lamp"}, int'(lamp), l);
    chk({req, " pdn"}, int'(pdn), p);
    chk({req, " char"}, int'(char_addr), c);
  endtask

  task automatic chk_all_zero(input string req);
    int v, nz;
    nz = 0;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) begin
        rd(c, r, v);
        if (v != 0) nz++;
      end
    chk({req, " nonzero rows"}, nz, 0);
  endtask

  initial begin
    int v;
    wclk(3); rst_ni = 1'b1; wclk(3);
    // R1
    chk_ctrl("R1", 0, 0, 0, 0);
    chk_all_zero("R1");

    // table walk: R3 framing exercised by every entry
    for (int i = 0; i < NV; i++) begin
      send_byte(VEC[i][15:8]);
      chk_ctrl($sformatf("R3/R5-R9 vec%0d", i), int'(VEC[i][7:5]), int'(VEC[i][4]),
               int'(VEC[i][3]), int'(VEC[i][2:0]));
    end

    // R4 row writes into char 1
    send_byte(8'hA1);
    send_byte(8'h1E); send_byte(8'h35); send_byte(8'h9F);
    rd(1, 0, v); chk("R4 row0", v, int'(rev5(5'h1E)));
    rd(1, 1, v); chk("R4 row1", v, int'(rev5(5'h15)));
    rd(1, 4, v); chk("R4 row4", v, 5'h1F);
    rd(0, 0, v); chk("R4 other char", v, 0);
    rd(1, 2, v); chk("R4 other row", v, 0);

    // R10 write during power down
    send_byte(8'hFF);
    send_byte(8'h51);
    rd(1, 2, v); chk("R10 stored", v, int'(rev5(5'h11)));
    chk("R10 pdn kept", int'(pdn), 1);

    // R6 ignored clear variant, then real clear
    send_byte(8'hC5);
    rd(1, 4, v); chk("R6 C5 ignored", v, 5'h1F);
    send_byte(8'hC0);
    chk_all_zero("R6 clear");

    // R2 and R11: previous byte A5, stray clocks outside frame, then 3-bit frame
    send_byte(8'hA5);
    for (int i = 0; i < 3; i++) pulse_bit(1'b1);
    send_bits(8'h00, 3);  // shift reg becomes {000, A5[7:3]} = 0x14 -> row 0 write
    rd(5, 0, v); chk("R11 partial row", v, int'(rev5(5'h14)));
    chk("R2 no stray shift bright", int'(bright), 6);
    chk("R2 no stray shift pdn", int'(pdn), 1);

    // R12 async reset mid-frame
    send_byte(8'hF2); send_byte(8'hA4); send_byte(8'h2A);
    frame_n = 1'b0; wclk(4); pulse_bit(1'b1); pulse_bit(1'b0);
    #3 rst_ni = 1'b0; #1;
    chk_ctrl("R12", 0, 0, 0, 0);
    rd(4, 1, v); chk("R12 ram", v, 0);
    frame_n = 1'b1; wclk(4); rst_ni = 1'b1; wclk(4);
    chk_ctrl("R12 after release", 0, 0, 0, 0);
    chk_all_zero("R12");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule